// File: doc/BRIEF.md
# System Control and Fault Status Register Block

This block is the software-facing side of a processor's system controller. The core reaches it through a simple word-indexed register port, with separate write and read strobes and a privilege flag. A write can ask for a system exception to be made pending or cleared. It can also move the vector table base, change the priority-group split, enable the three configurable fault handlers, raise a software interrupt, or clear sticky fault status bits. The exception arbiter and the fault detectors live outside the block. The arbiter takes the one-cycle pend strobes, the software trigger and the static configuration outputs. The detectors drive one-cycle event words into the three fault status registers.

Some registers guard their contents. The reset and priority-group register accepts a write only when the upper half of the data carries a fixed key. The software trigger obeys an interrupt count parameter and a privilege rule. The fault status words are sticky: hardware events set their bits, and software clears a bit by writing one to it.

Register indices used on `addr`: 0 pend control, 1 keyed reset/priority group, 2 vector base, 3 configuration control, 4 handler enables, 5 configurable fault status, 6 hard fault status, 7 debug fault status, 8 software trigger. Indices 9 and above are unmapped.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, every stored field is zero and every strobe and pulse output is low. A read of index 1 returns 0xFA050000.
- R2: A write to index 0 with bit 31 set gives a one-cycle `nmi_pend_set`. Bit 28 gives `pendsv_pend_set` and bit 27 gives `pendsv_pend_clr`. Bit 26 gives `systick_pend_set` and bit 25 gives `systick_pend_clr`. Each strobe is high only in the cycle after the write edge.
- R3: When the set bit and the clear bit of one pair (28/27 or 26/25) are written together, only the set strobe fires.
- R4: A write to index 1 takes effect only when bits 31:16 equal 0x05FA. When they do, bits 10:8 become `prio_group`, and bit 2 gives a one-cycle `sys_reset_req`. With any other key the write changes nothing.
- R5: A read of index 1 returns 0xFA05 in bits 31:16, the priority group in bits 10:8 and zero in all other bits.
- R6: A write to index 2 stores the data with bits 6:0 forced to zero. The result drives `vec_base` and reads back from index 2.
- R7: Index 3 keeps only bits 0, 1, 3, 4, 8 and 9 of a write. All other bits read as zero. Bit 1 is the user-pend permission.
- R8: At index 4, bits 16, 17 and 18 drive `fault_en[0]` (memory-manage), `fault_en[1]` (bus) and `fault_en[2]` (usage). A read returns them at the same bit positions.
- R9: Indices 5, 6 and 7 are write-one-to-clear. Each 1 in the written data clears the matching status bit, and 0 bits leave status unchanged.
- R10: A 1 on an event input sets the matching status bit at the next edge. This set wins over a software clear of the same bit in the same cycle.
- R11: A write to index 8 takes bits 8:0 as an interrupt number. It gives a one-cycle `swtrig_valid` with that number on `swtrig_num` only if the number is below `NUM_IRQ`.
- R12: The software trigger also requires `priv` high or the configuration bit 1 set. Otherwise it is dropped.
- R13: Indices 0, 8 and all unmapped indices read as zero. Writes to unmapped indices change no output and no register.
- R14: `rdata` is loaded at the edge where `rd_en` is high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rd_en | input | 1 | Read strobe for the register at `addr` |
| addr | input | ADDR_W | Register index |
| wdata | input | 32 | Write data |
| priv | input | 1 | Access is privileged |
| evt_cfg | input | FS_W | Configurable fault events, one cycle each |
| evt_hard | input | FS_W | Hard fault events |
| evt_dbg | input | FS_W | Debug fault events |
| rdata | output | 32 | Read data, one edge after `rd_en` |
| nmi_pend_set | output | 1 | Pend the non-maskable exception |
| pendsv_pend_set | output | 1 | Pend the deferred-service exception |
| pendsv_pend_clr | output | 1 | Clear the deferred-service pend |
| systick_pend_set | output | 1 | Pend the tick exception |
| systick_pend_clr | output | 1 | Clear the tick pend |
| sys_reset_req | output | 1 | System reset request pulse |
| prio_group | output | 3 | Priority-group split |
| vec_base | output | 32 | Vector table base address |
| fault_en | output | 3 | Handler enables: usage, bus, memory-manage |
| swtrig_valid | output | 1 | Software interrupt trigger pulse |
| swtrig_num | output | 9 | Interrupt number of the trigger |

## Verification
Every result of this block is registered once. Stored fields such as `prio_group`, `vec_base`, `fault_en` and the status words change at the same edge that samples the write. The pend strobes, `sys_reset_req` and `swtrig_valid` are high only in the cycle after that edge, and `rdata` carries a read one edge after `rd_en`. The bench changes inputs on falling edges and samples on the falling edge that follows the capturing rising edge, inside that single-cycle window. A second sample one cycle later shows that the strobes have dropped. Event pulses are put in the same cycle as a clearing write to test the set-over-clear priority.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 9;

    typedef enum logic [3:0] {
        RI_PEND    = 4'd0,
        RI_KEYED   = 4'd1,
        RI_VBASE   = 4'd2,
        RI_CFG     = 4'd3,
        RI_HCTL    = 4'd4,
        RI_FS_CFG  = 4'd5,
        RI_FS_HARD = 4'd6,
        RI_FS_DBG  = 4'd7,
        RI_SWTRIG  = 4'd8
    } reg_idx_e;

    localparam logic [15:0] WR_KEY = 16'h05FA;
    localparam logic [15:0] RD_KEY = 16'hFA05;

    // bit positions inside the pend control word
    localparam int B_NMI_SET = 31;
    localparam int B_SV_SET  = 28;
    localparam int B_SV_CLR  = 27;
    localparam int B_TK_SET  = 26;
    localparam int B_TK_CLR  = 25;

    // keyed register fields
    localparam int B_RESET_REQ = 2;
    localparam int B_GRP_LO    = 8;

    localparam logic [DATA_W-1:0] VBASE_MASK = 32'hFFFF_FF80;
    localparam logic [DATA_W-1:0] CFG_KEEP   = 32'h0000_031B;
    localparam int B_USERPEND = 1;
    localparam int B_HEN_LO   = 16;

    typedef struct packed {
        logic nmi_set;
        logic sv_set;
        logic sv_clr;
        logic tk_set;
        logic tk_clr;
    } pend_req_t;

    function automatic pend_req_t pend_decode(input logic [DATA_W-1:0] w);
        pend_req_t r;
        r.nmi_set = w[B_NMI_SET];
        r.sv_set  = w[B_SV_SET];
        r.sv_clr  = w[B_SV_CLR] & ~w[B_SV_SET];
        r.tk_set  = w[B_TK_SET];
        r.tk_clr  = w[B_TK_CLR] & ~w[B_TK_SET];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] keyed_readback(input logic [2:0] grp);
        logic [DATA_W-1:0] v;
        v = '0;
        v[31:16] = RD_KEY;
        v[B_GRP_LO +: 3] = grp;
        return v;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int ADDR_W = 4,
    parameter int NREG   = 9
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NREG-1:0]   sel_o
);
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_sel
            assign sel_o[g] = (addr_i == ADDR_W'(g));
        end
    endgenerate
endmodule

// File: rtl/sysctl_pend_ctrl.sv
module sysctl_pend_ctrl
    import sysctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output pend_req_t         req_o
);
    pend_req_t q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else if (wr_i) begin
            q <= pend_decode(wdata_i);
        end else begin
            q <= '0;
        end
    end

    assign req_o = q;

    // R2: a strobe only ever follows a write to the pend word
    p_strobe_cause_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (|q) |-> $past(wr_i));

    // R3: within a pair, set and clear never fire together
    p_pair_excl_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(q.sv_set && q.sv_clr) && !(q.tk_set && q.tk_clr));
endmodule

// File: rtl/sysctl_w1c_word.sv
module sysctl_w1c_word #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_mask_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;
    logic [W-1:0] clr_eff;

    assign clr_eff = clr_en_i ? clr_mask_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= (q & ~clr_eff) | set_i;
    end

    assign q_o = q;

    // R10: every event bit is present the cycle after it arrives
    p_hw_set_wins_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R9: cleared bits without a concurrent event are gone
    p_w1c_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_en_i |=> ((q_o & $past(clr_mask_i & ~set_i)) == '0));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_IRQ = 64,
    parameter int FS_W    = 32,
    parameter int IRQN_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              priv,
    input  logic [FS_W-1:0]   evt_cfg,
    input  logic [FS_W-1:0]   evt_hard,
    input  logic [FS_W-1:0]   evt_dbg,
    output logic [31:0]       rdata,
    output logic              nmi_pend_set,
    output logic              pendsv_pend_set,
    output logic              pendsv_pend_clr,
    output logic              systick_pend_set,
    output logic              systick_pend_clr,
    output logic              sys_reset_req,
    output logic [2:0]        prio_group,
    output logic [31:0]       vec_base,
    output logic [2:0]        fault_en,
    output logic              swtrig_valid,
    output logic [IRQN_W-1:0] swtrig_num
);
    localparam int NUM_FS = 3;

    logic [NUM_REGS-1:0] sel;
    pend_req_t           pend_q;

    logic we_pend, we_keyed, we_vbase, we_cfg, we_hctl, we_trig, we_unmapped;
    logic key_ok, trig_in_range, trig_allowed, trig_ok;
    logic [IRQN_W-1:0] trig_num_w;

    logic [2:0]        prio_q;
    logic              rstreq_q;
    logic [DATA_W-1:0] vbase_q;
    logic [DATA_W-1:0] cfg_q;
    logic [2:0]        hctl_q;
    logic              trig_v_q;
    logic [IRQN_W-1:0] trig_n_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    logic [FS_W-1:0] fs_evt [NUM_FS];
    logic [FS_W-1:0] fs_q   [NUM_FS];

    sysctl_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_decode (
        .addr_i (addr),
        .sel_o  (sel)
    );

    assign we_pend     = wr_en & sel[RI_PEND];
    assign we_keyed    = wr_en & sel[RI_KEYED];
    assign we_vbase    = wr_en & sel[RI_VBASE];
    assign we_cfg      = wr_en & sel[RI_CFG];
    assign we_hctl     = wr_en & sel[RI_HCTL];
    assign we_trig     = wr_en & sel[RI_SWTRIG];
    assign we_unmapped = wr_en & ~(|sel);

    assign key_ok        = (wdata[31:16] == WR_KEY);
    assign trig_num_w    = wdata[IRQN_W-1:0];
    assign trig_in_range = (32'(trig_num_w) < 32'(NUM_IRQ));
    assign trig_allowed  = priv | cfg_q[B_USERPEND];
    assign trig_ok       = trig_in_range & trig_allowed;

    sysctl_pend_ctrl u_pend (
        .clk_i   (clk),
        .rst_i   (rst),
        .wr_i    (we_pend),
        .wdata_i (wdata),
        .req_o   (pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q   <= '0;
            rstreq_q <= 1'b0;
            vbase_q  <= '0;
            cfg_q    <= '0;
            hctl_q   <= '0;
            trig_v_q <= 1'b0;
            trig_n_q <= '0;
        end else begin
            rstreq_q <= we_keyed & key_ok & wdata[B_RESET_REQ];
            if (we_keyed && key_ok) prio_q <= wdata[B_GRP_LO +: 3];
            if (we_vbase) vbase_q <= wdata & VBASE_MASK;
            if (we_cfg)   cfg_q   <= wdata & CFG_KEEP;
            if (we_hctl)  hctl_q  <= wdata[B_HEN_LO +: 3];
            trig_v_q <= we_trig & trig_ok;
            if (we_trig && trig_ok) trig_n_q <= trig_num_w;
        end
    end

    assign fs_evt[0] = evt_cfg;
    assign fs_evt[1] = evt_hard;
    assign fs_evt[2] = evt_dbg;

    generate
        for (genvar k = 0; k < NUM_FS; k++) begin : g_fs
            sysctl_w1c_word #(.W(FS_W)) u_fs (
                .clk_i      (clk),
                .rst_i      (rst),
                .clr_en_i   (wr_en & sel[int'(RI_FS_CFG) + k]),
                .clr_mask_i (wdata[FS_W-1:0]),
                .set_i      (fs_evt[k]),
                .q_o        (fs_q[k])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (sel[RI_KEYED])   rd_mux = keyed_readback(prio_q);
        if (sel[RI_VBASE])   rd_mux = vbase_q;
        if (sel[RI_CFG])     rd_mux = cfg_q;
        if (sel[RI_HCTL])    rd_mux[B_HEN_LO +: 3] = hctl_q;
        if (sel[RI_FS_CFG])  rd_mux = DATA_W'(fs_q[0]);
        if (sel[RI_FS_HARD]) rd_mux = DATA_W'(fs_q[1]);
        if (sel[RI_FS_DBG])  rd_mux = DATA_W'(fs_q[2]);
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata            = rdata_q;
    assign nmi_pend_set     = pend_q.nmi_set;
    assign pendsv_pend_set  = pend_q.sv_set;
    assign pendsv_pend_clr  = pend_q.sv_clr;
    assign systick_pend_set = pend_q.tk_set;
    assign systick_pend_clr = pend_q.tk_clr;
    assign sys_reset_req    = rstreq_q;
    assign prio_group       = prio_q;
    assign vec_base         = vbase_q;
    assign fault_en         = hctl_q;
    assign swtrig_valid     = trig_v_q;
    assign swtrig_num       = trig_n_q;

    // R4: a write with a bad key leaves the group and raises no reset
    p_key_guard_r4: assert property (@(posedge clk) disable iff (rst)
        (we_keyed && !key_ok) |=> ($stable(prio_group) && !sys_reset_req));

    // R6: vector base moves only on its own write
    p_vbase_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(we_vbase) |-> $stable(vec_base));

    // R7: configuration changes only on its own write
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(we_cfg) |-> $stable(cfg_q));

    // R11: a trigger never names an unimplemented interrupt
    p_trig_range_r11: assert property (@(posedge clk) disable iff (rst)
        swtrig_valid |-> (32'(swtrig_num) < 32'(NUM_IRQ)));

    // R12: a trigger needs privilege or the user-pend permission
    p_trig_gate_r12: assert property (@(posedge clk) disable iff (rst)
        swtrig_valid |-> ($past(priv) || $past(cfg_q[B_USERPEND])));

    // R13: unmapped writes leave the configuration outputs alone
    p_unmapped_r13: assert property (@(posedge clk) disable iff (rst)
        we_unmapped |=> ($stable(prio_group) && $stable(vec_base) && $stable(fault_en)));
endmodule

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        priv = 1'b0;
    logic [31:0] evt_cfg = '0;
    logic [31:0] evt_hard = '0;
    logic [31:0] evt_dbg = '0;
    logic [31:0] rdata;
    logic        nmi_pend_set, pendsv_pend_set, pendsv_pend_clr;
    logic        systick_pend_set, systick_pend_clr, sys_reset_req;
    logic [2:0]  prio_group;
    logic [31:0] vec_base;
    logic [2:0]  fault_en;
    logic        swtrig_valid;
    logic [8:0]  swtrig_num;

    int total = 0;
    int bad   = 0;

    logic [4:0] snap_pend;
    logic       snap_rst;
    logic       snap_trig;
    logic [8:0] snap_num;
    logic [31:0] rd_val;

    always #4 clk = ~clk;

    sysctl_regs dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .priv(priv), .evt_cfg(evt_cfg), .evt_hard(evt_hard),
        .evt_dbg(evt_dbg), .rdata(rdata), .nmi_pend_set(nmi_pend_set),
        .pendsv_pend_set(pendsv_pend_set), .pendsv_pend_clr(pendsv_pend_clr),
        .systick_pend_set(systick_pend_set), .systick_pend_clr(systick_pend_clr),
        .sys_reset_req(sys_reset_req), .prio_group(prio_group), .vec_base(vec_base),
        .fault_en(fault_en), .swtrig_valid(swtrig_valid), .swtrig_num(swtrig_num)
    );

    // {wdata, nmi_set, sv_set, sv_clr, tk_set, tk_clr}
    localparam logic [36:0] PEND_VEC [10] = '{
        {32'h8000_0000, 5'b10000},
        {32'h1000_0000, 5'b01000},
        {32'h0800_0000, 5'b00100},
        {32'h1800_0000, 5'b01000},
        {32'h0400_0000, 5'b00010},
        {32'h0200_0000, 5'b00001},
        {32'h0600_0000, 5'b00010},
        {32'h9E00_0000, 5'b11010},
        {32'h0A00_0000, 5'b00101},
        {32'h61FF_FFFF, 5'b00000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic snap();
        snap_pend = {nmi_pend_set, pendsv_pend_set, pendsv_pend_clr,
                     systick_pend_set, systick_pend_clr};
        snap_rst  = sys_reset_req;
        snap_trig = swtrig_valid;
        snap_num  = swtrig_num;
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [31:0] d, input logic p);
        @(negedge clk);
        wr_en = 1'b1; addr = idx; wdata = d; priv = p;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; priv = 1'b0;
        snap();
    endtask

    task automatic do_read(input logic [3:0] idx);
        @(negedge clk);
        rd_en = 1'b1; addr = idx;
        @(negedge clk);
        rd_en = 1'b0;
        rd_val = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        snap();
        check("R1 strobes", {27'b0, snap_pend}, 32'h0);
        check("R1 reset req", {31'b0, snap_rst}, 32'h0);
        check("R1 prio", {29'b0, prio_group}, 32'h0);
        check("R1 vec", vec_base, 32'h0);
        check("R1 fault_en", {29'b0, fault_en}, 32'h0);
        do_read(4'd1);
        check("R1 R5 keyed read", rd_val, 32'hFA05_0000);
        do_read(4'd5);
        check("R1 fault status", rd_val, 32'h0);

        // R2 R3 table of pend writes
        for (int i = 0; i < 10; i++) begin
            do_write(4'd0, PEND_VEC[i][36:5], 1'b1);
            check("R2 R3 pend strobes", {27'b0, snap_pend}, {27'b0, PEND_VEC[i][4:0]});
        end
        do_write(4'd0, 32'hFE00_0000, 1'b0);
        @(negedge clk);
        snap();
        check("R2 strobes one cycle", {27'b0, snap_pend}, 32'h0);

        // R4 R5 keyed register
        do_write(4'd1, 32'h05FA_0704, 1'b1);
        check("R4 reset pulse", {31'b0, snap_rst}, 32'h1);
        check("R4 group", {29'b0, prio_group}, 32'h7);
        @(negedge clk);
        check("R4 reset pulse drops", {31'b0, sys_reset_req}, 32'h0);
        do_read(4'd1);
        check("R5 keyed readback", rd_val, 32'hFA05_0700);
        do_write(4'd1, 32'h05FB_0304, 1'b1);
        check("R4 bad key no pulse", {31'b0, snap_rst}, 32'h0);
        check("R4 bad key group kept", {29'b0, prio_group}, 32'h7);
        do_write(4'd1, 32'h05FA_0200, 1'b1);
        check("R4 no reset bit", {31'b0, snap_rst}, 32'h0);
        check("R4 group update", {29'b0, prio_group}, 32'h2);

        // R6 vector base
        do_write(4'd2, 32'hFFFF_FFFF, 1'b1);
        check("R6 vec out", vec_base, 32'hFFFF_FF80);
        do_read(4'd2);
        check("R6 vec read", rd_val, 32'hFFFF_FF80);

        // R7 configuration
        do_write(4'd3, 32'hFFFF_FFFF, 1'b1);
        do_read(4'd3);
        check("R7 cfg keep", rd_val, 32'h0000_031B);

        // R8 handler enables
        do_write(4'd4, 32'h0007_0000, 1'b1);
        check("R8 all enables", {29'b0, fault_en}, 32'h7);
        do_write(4'd4, 32'hFFF2_FFFF, 1'b1);
        check("R8 bus only", {29'b0, fault_en}, 32'h2);
        do_read(4'd4);
        check("R8 readback", rd_val, 32'h0002_0000);

        // R9 R10 fault status
        @(negedge clk);
        evt_cfg = 32'hA5A5_A5A5; evt_hard = 32'hF0F0_F0F0; evt_dbg = 32'h0000_001F;
        @(negedge clk);
        evt_cfg = '0; evt_hard = '0; evt_dbg = '0;
        do_read(4'd5);
        check("R10 event sets", rd_val, 32'hA5A5_A5A5);
        do_write(4'd5, 32'h0000_FFFF, 1'b1);
        do_read(4'd5);
        check("R9 w1c cfg", rd_val, 32'hA5A5_0000);
        do_write(4'd6, 32'hFFFF_0000, 1'b0);
        do_read(4'd6);
        check("R9 w1c hard", rd_val, 32'h0000_F0F0);
        do_write(4'd7, 32'h0000_0003, 1'b0);
        do_read(4'd7);
        check("R9 w1c dbg", rd_val, 32'h0000_001C);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd5; wdata = 32'h0000_0001; evt_cfg = 32'h0000_0001;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt_cfg = '0;
        do_read(4'd5);
        check("R10 set beats clear", rd_val, 32'hA5A5_0001);

        // R11 R12 software trigger
        do_write(4'd3, 32'h0000_0000, 1'b1);
        do_write(4'd8, 32'd5, 1'b0);
        check("R12 unpriv blocked", {31'b0, snap_trig}, 32'h0);
        do_write(4'd8, 32'd5, 1'b1);
        check("R11 priv valid", {31'b0, snap_trig}, 32'h1);
        check("R11 priv num", {23'b0, snap_num}, 32'd5);
        do_write(4'd8, 32'd64, 1'b1);
        check("R11 at limit dropped", {31'b0, snap_trig}, 32'h0);
        do_write(4'd8, 32'd63, 1'b1);
        check("R11 below limit", {31'b0, snap_trig}, 32'h1);
        check("R11 num 63", {23'b0, snap_num}, 32'd63);
        do_write(4'd8, 32'hFFFF_FE05, 1'b1);
        check("R11 low 9 bits", {22'b0, snap_trig, snap_num}, {22'b0, 1'b1, 9'd5});
        do_write(4'd3, 32'h0000_0002, 1'b1);
        do_write(4'd8, 32'd7, 1'b0);
        check("R12 user pend allows", {22'b0, snap_trig, snap_num}, {22'b0, 1'b1, 9'd7});

        // R13 unmapped and write-only indices
        for (int a = 9; a < 16; a++) begin
            do_write(4'(a), 32'hFFFF_FFFF, 1'b1);
            do_read(4'(a));
            check("R13 unmapped read", rd_val, 32'h0);
        end
        check("R13 group kept", {29'b0, prio_group}, 32'h2);
        check("R13 vec kept", vec_base, 32'hFFFF_FF80);
        check("R13 enables kept", {29'b0, fault_en}, 32'h2);
        do_read(4'd0);
        check("R13 pend word reads zero", rd_val, 32'h0);
        do_read(4'd8);
        check("R13 trigger reads zero", rd_val, 32'h0);

        // R14 rdata holds between reads
        do_read(4'd2);
        addr = 4'd1;
        repeat (3) @(negedge clk);
        check("R14 rdata hold", rdata, 32'hFFFF_FF80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule